// File: doc/BRIEF.md
# Aligned Mantissa Summation Stage

This block closes the data path of a floating-point adder. It receives two mantissas that an earlier stage has already aligned to a common exponent. It also receives the two operand sign bits and the exponent chosen by that earlier stage. The mantissas are summed by a chain of single-bit full-adder stages. The carry out of the top stage is reported next to the truncated sum.

A fixed rule set derives the result sign and a single range flag from two inputs: the exclusive-or of the operand signs, and that carry. When both operands are positive and the sum carries out, the flag reports an overflow. When both operands are negative and the sum does not carry out, the flag reports an underflow. When the signs differ, the flag stays low. A later rounding and normalising stage uses this flag. The block does not normalise, round or adjust the exponent.

One register stage holds all results. A qualifying strobe travels through that stage alongside the data, so sum, carry, sign, flag and exponent become valid together.

Top module: `mant_sum_unit`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `sum_mant` equals (`a_mant` + `b_mant`) modulo 2^MW, where MW is the mantissa width (23 by default).
- R2: In that same cycle, `carry_out` equals bit MW of the full sum `a_mant` + `b_mant`, with a carry-in of 0 into bit 0.
- R3: When `a_sign` equals `b_sign`, `res_sign` equals that common sign.
- R4: When `a_sign` differs from `b_sign`, `res_sign` is 1 if `carry_out` is 0, and 0 if `carry_out` is 1.
- R5: When both signs are 0, `range_flag` is 1 exactly when `carry_out` is 1.
- R6: When both signs are 1, `range_flag` is 1 exactly when `carry_out` is 0.
- R7: When the signs differ, `range_flag` is 0.
- R8: One cycle after an accepted input, `exp_out` equals the `exp_in` that was presented with it.
- R9: `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, all data outputs keep their values.
- R10: While `rst_n` is low, and after it, until the first accepted input, `out_valid`, `sum_mant`, `carry_out`, `res_sign`, `range_flag` and `exp_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Inputs are valid this cycle |
| a_mant | input | MW | First aligned mantissa |
| b_mant | input | MW | Second aligned mantissa |
| a_sign | input | 1 | Sign of first operand |
| b_sign | input | 1 | Sign of second operand |
| exp_in | input | EW | Exponent chosen by alignment |
| out_valid | output | 1 | Results valid this cycle |
| sum_mant | output | MW | Truncated mantissa sum |
| carry_out | output | 1 | Carry from the top stage |
| res_sign | output | 1 | Result sign |
| range_flag | output | 1 | Overflow or underflow indication |
| exp_out | output | EW | Exponent passed through |

## Verification
Every result is due exactly one clock edge after the cycle in which `in_valid` was high. No result appears earlier than that edge, and none appears later.

The bench drives each input on a falling edge. It compares all five data outputs and `out_valid` on the next falling edge, which follows the single register edge. Hold behaviour is checked the same way: the bench changes the inputs with `in_valid` low and compares again on the next falling edge.

// File: rtl/mant_sum_unit.sv
module mant_sum_unit #(
  parameter int MW = 23,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [MW-1:0] a_mant,
  input  logic [MW-1:0] b_mant,
  input  logic          a_sign,
  input  logic          b_sign,
  input  logic [EW-1:0] exp_in,
  output logic          out_valid,
  output logic [MW-1:0] sum_mant,
  output logic          carry_out,
  output logic          res_sign,
  output logic          range_flag,
  output logic [EW-1:0] exp_out
);

  logic [MW:0]   chain;
  logic [MW-1:0] sum_w;
  logic          sx;
  logic          sign_w;
  logic          flag_w;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < MW; i++) begin : g_stage
    logic p;
    assign p            = a_mant[i] ^ b_mant[i];
    assign sum_w[i]     = p ^ chain[i];
    assign chain[i+1]   = (a_mant[i] & b_mant[i]) | (p & chain[i]);
  end

  assign sx     = a_sign ^ b_sign;
  assign sign_w = sx ? ~chain[MW] : a_sign;
  assign flag_w = sx ? 1'b0 : (a_sign ? ~chain[MW] : chain[MW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      sum_mant   <= '0;
      carry_out  <= 1'b0;
      res_sign   <= 1'b0;
      range_flag <= 1'b0;
      exp_out    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_mant   <= sum_w;
        carry_out  <= chain[MW];
        res_sign   <= sign_w;
        range_flag <= flag_w;
        exp_out    <= exp_in;
      end
    end
  end

endmodule

// File: rtl/mant_sum_unit_chk.sv
module mant_sum_unit_chk #(
  parameter int MW = 23,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          a_sign,
  input logic          b_sign,
  input logic [EW-1:0] exp_in,
  input logic          out_valid,
  input logic [MW-1:0] sum_mant,
  input logic          carry_out,
  input logic          res_sign,
  input logic          range_flag,
  input logic [EW-1:0] exp_out
);

  a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum_mant) && $stable(carry_out) && $stable(exp_out)));

  a_r8_exp_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> exp_out == $past(exp_in));

  a_r3_same_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_sign == b_sign) |=> res_sign == $past(a_sign));

  a_r4_mixed_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_sign != b_sign) |=> res_sign != carry_out);

  a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_sign && !b_sign) |=> range_flag == carry_out);

  a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_sign && b_sign) |=> range_flag != carry_out);

  a_r7_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_sign != b_sign) |=> !range_flag);

endmodule

bind mant_sum_unit mant_sum_unit_chk #(.MW(MW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_sign(a_sign),
  .b_sign(b_sign), .exp_in(exp_in), .out_valid(out_valid),
  .sum_mant(sum_mant), .carry_out(carry_out), .res_sign(res_sign),
  .range_flag(range_flag), .exp_out(exp_out)
);

// File: tb/mant_sum_unit_tb_top.sv
module mant_sum_unit_tb_top;
  localparam int MW = 23;
  localparam int EW = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [MW-1:0] a;
    logic [MW-1:0] b;
    logic          sa;
    logic          sb;
    logic [EW-1:0] e;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{23'h000001, 23'h000002, 1'b0, 1'b0, 8'h10},
    '{23'h7FFFFF, 23'h000001, 1'b0, 1'b0, 8'h81},
    '{23'h400000, 23'h400000, 1'b1, 1'b1, 8'hFE},
    '{23'h123456, 23'h000100, 1'b1, 1'b1, 8'h00},
    '{23'h600000, 23'h300000, 1'b0, 1'b1, 8'h7F},
    '{23'h000010, 23'h000020, 1'b1, 1'b0, 8'h22},
    '{23'h2AAAAA, 23'h555555, 1'b0, 1'b0, 8'h55},
    '{23'h000000, 23'h000000, 1'b1, 1'b1, 8'hAA}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [MW-1:0] a_mant = '0, b_mant = '0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] exp_in = '0;
  logic out_valid, carry_out, res_sign, range_flag;
  logic [MW-1:0] sum_mant;
  logic [EW-1:0] exp_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mant_sum_unit #(.MW(MW), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_mant(a_mant),
    .b_mant(b_mant), .a_sign(a_sign), .b_sign(b_sign), .exp_in(exp_in),
    .out_valid(out_valid), .sum_mant(sum_mant), .carry_out(carry_out),
    .res_sign(res_sign), .range_flag(range_flag), .exp_out(exp_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(input vec_t v);
    logic [MW:0] full;
    logic ex_sign, ex_flag, c;
    full = {1'b0, v.a} + {1'b0, v.b};
    c = full[MW];
    if (v.sa == v.sb) ex_sign = v.sa;        // R3
    else              ex_sign = (c == 1'b0);  // R4
    if (v.sa != v.sb)      ex_flag = 1'b0;    // R7
    else if (v.sa == 1'b0) ex_flag = c;       // R5
    else                   ex_flag = ~c;      // R6
    a_mant = v.a; b_mant = v.b; a_sign = v.sa; b_sign = v.sb; exp_in = v.e;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R9 out_valid", 32'(out_valid), 32'd1);
    check(sum_mant == full[MW-1:0], "R1 sum_mant", 32'(sum_mant), 32'(full[MW-1:0]));
    check(carry_out == c, "R2 carry_out", 32'(carry_out), 32'(c));
    check(res_sign == ex_sign, (v.sa == v.sb) ? "R3 res_sign" : "R4 res_sign",
          32'(res_sign), 32'(ex_sign));
    check(range_flag == ex_flag,
          (v.sa != v.sb) ? "R7 range_flag" : (v.sa ? "R6 range_flag" : "R5 range_flag"),
          32'(range_flag), 32'(ex_flag));
    check(exp_out == v.e, "R8 exp_out", 32'(exp_out), 32'(v.e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'd0);
    check(sum_mant == '0 && carry_out == 1'b0 && exp_out == '0,
          "R10 data in reset", 32'(sum_mant), 32'd0);
    check(res_sign == 1'b0 && range_flag == 1'b0, "R10 sign/flag in reset",
          32'({res_sign, range_flag}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && sum_mant == '0, "R10 idle after reset",
          32'(out_valid), 32'd0);

    for (int k = 0; k < NV; k++) apply_and_check(VECS[k]);

    // R9: hold while in_valid low, with changed inputs
    a_mant = 23'h7FFFFF; b_mant = 23'h7FFFFF; a_sign = 1'b0; b_sign = 1'b1; exp_in = 8'h33;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid drops", 32'(out_valid), 32'd0);
    check(sum_mant == '0 && carry_out == 1'b0, "R9 sum held", 32'(sum_mant), 32'd0);
    check(exp_out == 8'hAA && res_sign == 1'b1 && range_flag == 1'b1,
          "R9 exp/sign/flag held", 32'({exp_out, res_sign, range_flag}), 32'({8'hAA, 2'b11}));

    // Boundary: largest operands, mixed signs
    apply_and_check('{23'h7FFFFF, 23'h7FFFFF, 1'b1, 1'b0, 8'hFF});
    // Back-to-back inputs
    in_valid = 1'b1;
    a_mant = 23'h000003; b_mant = 23'h000004; a_sign = 1'b1; b_sign = 1'b1; exp_in = 8'h01;
    @(negedge clk);
    a_mant = 23'h7FFFF0; b_mant = 23'h000010; a_sign = 1'b0; b_sign = 1'b0; exp_in = 8'h02;
    check(sum_mant == 23'h7 && range_flag == 1'b1, "R6 back-to-back first",
          32'({sum_mant, range_flag}), 32'({23'h7, 1'b1}));
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && sum_mant == '0 && carry_out == 1'b1 && range_flag == 1'b1,
          "R5 back-to-back second", 32'({sum_mant, carry_out, range_flag}), 32'(3'b011));
    check(exp_out == 8'h02, "R8 back-to-back exp", 32'(exp_out), 32'h02);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule